// File: doc/BRIEF.md
# Machine-Cycle Reset Qualifier

This block turns an asynchronous, active-high reset pin into the internal reset of a core whose machine cycle is twelve clocks long. A two-flop synchronizer first brings the pin into the clock domain. A free-running phase counter (0 to 11) then picks one clock edge per machine cycle, phase 9 (state 5, second half), at which the synchronized pin is sampled. A single high sample is not enough. The core reset asserts only when the pin has been seen high on two consecutive samples, and it releases at the first sample that finds the pin low.

A second output drives the port pins into their reset state. The ports keep their current activity for 19 clocks, counted from the first high sample, and then this output asserts. If the next sample finds the pin low, the timer is cancelled. The block also presents the values that registers take on reset: FFh for port latches, 07h for the stack pointer, and 00h for the other control registers. It uses its own synchronous active-high initialization input `rst` to start the phase counter and clear its flops.

Top module: `mc_reset_sampler`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `core_rst` and `port_rst` are 0. The phase counter restarts at 0, so the first sampling edge is the 10th rising edge after `rst` falls, and a sampling edge follows every 12 edges after that.
- R2: The pin is observed only on sampling edges. A high pulse that has left the synchronizer before a sampling edge has no effect on either output.
- R3: `core_rst` rises on the sampling edge that finds the pin high for the second consecutive time. One isolated high sample, or two high samples with a low sample between them, leaves `core_rst` at 0.
- R4: The pin passes through two flops before sampling. A pin that rises two clocks before a sampling edge is seen by that edge. A pin that rises one clock before it is seen only by the next sampling edge.
- R5: `port_rst` rises exactly 19 clock edges after the first high sample. While `port_rst` is high, `core_rst` is high.
- R6: If a sample finds the pin low before the 19-clock timer expires, the timer is cancelled and `port_rst` stays 0.
- R7: `core_rst` and `port_rst` both fall on the first sampling edge that finds the pin low. A low excursion of the pin that starts and ends between two sampling edges releases neither output.
- R8: `port_latch_init` is FFh, `stack_init` is 07h and `sfr_init` is 00h.
- R9: The phase counter keeps running while `core_rst` is high, so the release edge falls on the regular 12-clock sampling schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high initialization of the block |
| rst_pin | input | 1 | Asynchronous active-high reset pin |
| core_rst | output | 1 | Qualified internal reset for the core |
| port_rst | output | 1 | Forces the port pins into their reset state |
| port_latch_init | output | 8 | Reset value of the port latches |
| stack_init | output | 8 | Reset value of the stack pointer |
| sfr_init | output | 8 | Reset value of the other control registers |

## Verification
The bench places pin edges exactly one and two clocks ahead of a sampling edge. A design with one flop too many or too few in the synchronizer would assert the reset a full machine cycle early or late. Short pulses are checked against the qualification rule: one that covers a single sample, one that falls between samples, and two high samples split by a low one. A design that qualifies on one sample, or that samples on every clock, would raise `core_rst` in these cases. The bench also times `port_rst` to the exact 19th edge, shows that an aborted timer never fires, and drops the pin briefly between samples while reset is held. A design that released on any low level, or that stalled its phase counter during reset, would release early or off the 12-clock grid.

// File: rtl/mc_reset_pkg.sv
package mc_reset_pkg;
  localparam int unsigned CYC_LEN   = 12; // clocks per machine cycle
  localparam int unsigned SMP_PHASE = 9;  // state 5, second half
  localparam int unsigned QUAL_CNT  = 2;  // consecutive high samples
  localparam int unsigned PORT_DLY  = 19; // clocks until ports are forced
  localparam int unsigned SYNC_LEN  = 2;  // synchronizer flops
  localparam logic [7:0]  PORT_INIT = 8'hFF;
  localparam logic [7:0]  SP_INIT   = 8'h07;
  localparam logic [7:0]  SFR_INIT  = 8'h00;
endpackage

// File: rtl/mc_pin_sync.sv
module mc_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mc_phase_gen.sv
module mc_phase_gen #(
  parameter int unsigned CYC_LEN   = 12,
  parameter int unsigned SMP_PHASE = 9
) (
  input  logic clk,
  input  logic rst,
  output logic stb
);
  localparam int unsigned PW = $clog2(CYC_LEN);
  localparam logic [PW-1:0] LAST = PW'(CYC_LEN - 1);
  localparam logic [PW-1:0] SPH  = PW'(SMP_PHASE);

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst)             ph <= '0;
    else if (ph == LAST) ph <= '0;
    else                 ph <= ph + 1'b1;
  end

  assign stb = (ph == SPH);

  // R9
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == LAST) |=> (ph == '0));
  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ph != LAST) |=> (ph == $past(ph) + 1'b1));
endmodule

// File: rtl/mc_reset_qual.sv
module mc_reset_qual #(
  parameter int unsigned QUAL_CNT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic smp,
  output logic core_rst
);
  localparam int unsigned HW = $clog2(QUAL_CNT + 1);
  localparam logic [HW-1:0] QMAX = HW'(QUAL_CNT);
  localparam logic [HW-1:0] QPRE = HW'(QUAL_CNT - 1);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      core_rst <= 1'b0;
    end else if (stb) begin
      if (smp) begin
        if (hi_cnt != QMAX) hi_cnt <= hi_cnt + 1'b1;
        if (hi_cnt >= QPRE) core_rst <= 1'b1;
      end else begin
        hi_cnt   <= '0;
        core_rst <= 1'b0;
      end
    end
  end

  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(core_rst));
  // R7
  release_low_chk: assert property (@(posedge clk) disable iff (rst)
    (stb && !smp) |=> !core_rst);
endmodule

// File: rtl/mc_port_timer.sv
module mc_port_timer #(
  parameter int unsigned PORT_DLY = 19
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic smp,
  output logic port_rst
);
  localparam int unsigned DW = $clog2(PORT_DLY);
  localparam logic [DW-1:0] LIM = DW'(PORT_DLY - 1);

  logic          run;
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      cnt      <= '0;
      port_rst <= 1'b0;
    end else if (stb && !smp) begin
      run      <= 1'b0;
      port_rst <= 1'b0;
    end else if (stb && smp && !run && !port_rst) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      if (cnt == LIM) begin
        run      <= 1'b0;
        port_rst <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5
  run_excl_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> !port_rst);
  // R6
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (stb && !smp) |=> (!port_rst && !run));
endmodule

// File: rtl/mc_reset_sampler.sv
module mc_reset_sampler
  import mc_reset_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_pin,
  output logic       core_rst,
  output logic       port_rst,
  output logic [7:0] port_latch_init,
  output logic [7:0] stack_init,
  output logic [7:0] sfr_init
);
  logic pin_s;
  logic stb;

  mc_pin_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .din(rst_pin), .dout(pin_s)
  );

  mc_phase_gen #(.CYC_LEN(CYC_LEN), .SMP_PHASE(SMP_PHASE)) u_phase (
    .clk(clk), .rst(rst), .stb(stb)
  );

  mc_reset_qual #(.QUAL_CNT(QUAL_CNT)) u_qual (
    .clk(clk), .rst(rst), .stb(stb), .smp(pin_s), .core_rst(core_rst)
  );

  mc_port_timer #(.PORT_DLY(PORT_DLY)) u_port (
    .clk(clk), .rst(rst), .stb(stb), .smp(pin_s), .port_rst(port_rst)
  );

  assign port_latch_init = PORT_INIT;
  assign stack_init      = SP_INIT;
  assign sfr_init        = SFR_INIT;

  // R5
  port_in_core_chk: assert property (@(posedge clk) disable iff (rst)
    port_rst |-> core_rst);
endmodule

// File: tb/tb_mc_reset_sampler.sv
module tb_mc_reset_sampler;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rst_pin = 1'b0;
  logic       core_rst, port_rst;
  logic [7:0] port_latch_init, stack_init, sfr_init;

  int unsigned total = 0;
  int unsigned failed = 0;
  int unsigned cyc = 0;
  int unsigned wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_reset_sampler dut (
    .clk(clk), .rst(rst), .rst_pin(rst_pin),
    .core_rst(core_rst), .port_rst(port_rst),
    .port_latch_init(port_latch_init), .stack_init(stack_init),
    .sfr_init(sfr_init)
  );

  always @(posedge clk) begin
    wd++;
    if (wd == 20000) begin
      total++;
      failed++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", wd);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    rst_pin = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cyc = 0;
  endtask

  task automatic run_to(input int unsigned k);
    while (cyc < k) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  // Watches both outputs up to edge k; returns 1 if either went high.
  task automatic watch_quiet(input int unsigned k, output logic seen);
    seen = 1'b0;
    while (cyc < k) begin
      run_to(cyc + 1);
      if (core_rst || port_rst) seen = 1'b1;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 core_rst after init", {7'd0, core_rst}, 8'd0);
    chk("R1 port_rst after init", {7'd0, port_rst}, 8'd0);
    chk("R8 port latch value", port_latch_init, 8'hFF);
    chk("R8 stack value", stack_init, 8'h07);
    chk("R8 other register value", sfr_init, 8'h00);
  endtask

  task automatic t_full_cycle();
    do_reset();
    run_to(7); rst_pin = 1'b1;          // first high sample at edge 10
    run_to(21); chk("R3 not yet qualified", {7'd0, core_rst}, 8'd0);
    run_to(22); chk("R3 core_rst on second sample", {7'd0, core_rst}, 8'd1);
    run_to(26); rst_pin = 1'b0;         // dip between samples
    run_to(28); chk("R5 port_rst edge 18 after first", {7'd0, port_rst}, 8'd0);
    rst_pin = 1'b1;
    run_to(29); chk("R5 port_rst at 19 edges", {7'd0, port_rst}, 8'd1);
    run_to(34); chk("R7 dip between samples ignored", {7'd0, core_rst}, 8'd1);
    run_to(40); rst_pin = 1'b0;         // low sample at edge 46
    run_to(45);
    chk("R9 core_rst held before release sample", {7'd0, core_rst}, 8'd1);
    chk("R7 port_rst held before release sample", {7'd0, port_rst}, 8'd1);
    run_to(46);
    chk("R9 core_rst released on grid", {7'd0, core_rst}, 8'd0);
    chk("R7 port_rst released with core", {7'd0, port_rst}, 8'd0);
  endtask

  task automatic t_single_sample();
    logic seen;
    do_reset();
    run_to(7); rst_pin = 1'b1;          // high at edge 10 only
    run_to(19); rst_pin = 1'b0;         // low at edge 22
    watch_quiet(40, seen);
    chk("R3 R6 single high sample", {7'd0, seen}, 8'd0);
  endtask

  task automatic t_split_samples();
    logic seen;
    do_reset();
    run_to(7); rst_pin = 1'b1;          // high at 10
    run_to(19); rst_pin = 1'b0;         // low at 22
    run_to(31); rst_pin = 1'b1;         // high at 34
    run_to(43); rst_pin = 1'b0;         // low at 46
    watch_quiet(60, seen);
    chk("R3 non-consecutive highs", {7'd0, seen}, 8'd0);
  endtask

  task automatic t_glitch();
    logic seen;
    do_reset();
    run_to(12); rst_pin = 1'b1;
    run_to(15); rst_pin = 1'b0;         // gone before edge 22
    watch_quiet(40, seen);
    chk("R2 pulse between samples", {7'd0, seen}, 8'd0);
  endtask

  task automatic t_sync_latency();
    do_reset();
    run_to(8); rst_pin = 1'b1;          // one clock short for edge 10
    run_to(22); chk("R4 first sample 22 only", {7'd0, core_rst}, 8'd0);
    run_to(33); chk("R4 not qualified before 34", {7'd0, core_rst}, 8'd0);
    run_to(34); chk("R4 qualified at 34", {7'd0, core_rst}, 8'd1);
    run_to(40); chk("R5 port_rst edge 40", {7'd0, port_rst}, 8'd0);
    run_to(41); chk("R5 port_rst edge 41", {7'd0, port_rst}, 8'd1);
    rst_pin = 1'b0;                     // low sample at 46
    run_to(45); chk("R7 still held at 45", {7'd0, core_rst}, 8'd1);
    run_to(46); chk("R7 released at 46", {7'd0, core_rst}, 8'd0);
  endtask

  initial begin
    t_reset_state();
    t_full_cycle();
    t_single_sample();
    t_split_samples();
    t_glitch();
    t_sync_latency();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule